// File: doc/BRIEF.md
# Flag-and-Mask Interrupt Controller

This block collects two interrupt sources for a small processor core: a one-cycle overflow pulse from a timer, and a falling edge on an external interrupt pin. Each source owns a sticky flag in a status register, and a companion mask register decides which flags may raise a request. A single global enable, set and cleared by strobes from the core, gates the combined request.

A flag sets on its event whatever the mask and the global enable hold. Software may only clear flags through the status write port and can never set them. Reading status returns the flags already ANDed with the mask. When the request is taken, the global enable drops at once, so the core sees a request for a single cycle. A return-from-interrupt strobe restores the global enable. Vector selection and return-address handling belong to the core.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is asserted (active low, asynchronous), both flags, both mask bits and the global enable are 0. `stat_rdata`, `mask_rdata` and `irq_req` then read 0.
- R2: A high `tmr_ovf` at a clock edge sets the timer flag (status bit 0) at that edge, whatever the mask and the global enable hold.
- R3: A falling edge of `ext_pin` (1 at the previous edge, 0 at this edge) sets the external flag (status bit 3) at this edge. A rising edge or a steady level sets nothing.
- R4: A status write clears each flag whose data bit (bit 0 timer, bit 3 external) is 0 and leaves each flag whose data bit is 1 unchanged. A write never sets a flag.
- R5: `stat_rdata` bit 0 is timer flag AND timer mask, and bit 3 is external flag AND external mask. All other bits are 0.
- R6: A mask write stores data bit 0 as the timer mask and data bit 3 as the external mask. `mask_rdata` shows those two bits in place and 0 elsewhere.
- R7: `irq_req` is 1 exactly when the global enable is 1 and at least one flag is 1 together with its mask bit.
- R8: `gie_set` or `ret_strobe` sets the global enable and `gie_clr` clears it. When `gie_clr` and a set strobe arrive in the same cycle, the clear wins.
- R9: When `irq_req` is 1 at a clock edge, the global enable is cleared at that edge, whatever strobes are present.
- R10: When a flag's hardware set event and a status write clearing it fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | External interrupt pin, synchronous to clk |
| stat_we | input | 1 | Status write strobe (clear-only) |
| stat_wdata | input | 8 | Status write data; 0 in a flag bit clears it |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| gie_set | input | 1 | Global enable set strobe |
| gie_clr | input | 1 | Global enable clear strobe |
| ret_strobe | input | 1 | Return-from-interrupt strobe, sets the global enable |
| stat_rdata | output | 8 | Flags ANDed with mask |
| mask_rdata | output | 8 | Mask readback |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Every state change lands on the first clock edge after its stimulus. A timer pulse, a pin fall, a write or a strobe shows on `stat_rdata`, `mask_rdata` or `irq_req` after exactly one edge, because the readbacks and the request are combinational from the registers. The hardware clear of the global enable drops `irq_req` one edge after it first rises. The bench drives each stimulus after a falling edge, lets one rising edge pass, and compares at the next falling edge. A sequence that needs two edges, such as request-then-take, is two table rows.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int DW      = 8,
  parameter int TMR_BIT = 0,
  parameter int EXT_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_ovf,
  input  logic          ext_pin,
  input  logic          stat_we,
  input  logic [DW-1:0] stat_wdata,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          ret_strobe,
  output logic [DW-1:0] stat_rdata,
  output logic [DW-1:0] mask_rdata,
  output logic          irq_req
);

  logic tmr_f, ext_f, tmr_m, ext_m, gie, ext_q;
  logic unused_wdata;

  assign unused_wdata = ^{stat_wdata, mask_wdata};

  wire ext_fall = ext_q & ~ext_pin;
  wire tmr_hit  = tmr_f & tmr_m;
  wire ext_hit  = ext_f & ext_m;

  assign irq_req = gie & (tmr_hit | ext_hit);

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[TMR_BIT] = tmr_hit;
    stat_rdata[EXT_BIT] = ext_hit;
    mask_rdata          = '0;
    mask_rdata[TMR_BIT] = tmr_m;
    mask_rdata[EXT_BIT] = ext_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b1;
      tmr_f <= 1'b0;
      ext_f <= 1'b0;
      tmr_m <= 1'b0;
      ext_m <= 1'b0;
      gie   <= 1'b0;
    end else begin
      ext_q <= ext_pin;

      if (tmr_ovf)                             tmr_f <= 1'b1;
      else if (stat_we && !stat_wdata[TMR_BIT]) tmr_f <= 1'b0;

      if (ext_fall)                            ext_f <= 1'b1;
      else if (stat_we && !stat_wdata[EXT_BIT]) ext_f <= 1'b0;

      if (mask_we) begin
        tmr_m <= mask_wdata[TMR_BIT];
        ext_m <= mask_wdata[EXT_BIT];
      end

      if (irq_req || gie_clr)          gie <= 1'b0;
      else if (gie_set || ret_strobe)  gie <= 1'b1;
    end
  end

  // R2 / R10: timer event always leaves the flag set
  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_f);

  // R3: a pin fall sets the external flag
  p_ext_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !ext_pin) |=> ext_f);

  // R4: without an event a clear flag stays clear
  p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_f && !tmr_ovf) |=> !tmr_f);

  // R5: no bit reads set unless its mask bit is set
  p_read_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & ~mask_rdata) == '0);

  // R8: enable only rises after a set or return strobe
  p_gie_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(gie_set || ret_strobe));

  // R9: a taken request drops the enable at once
  p_take_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !gie);

  // R10: external set beats a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !ext_pin && stat_we && !stat_wdata[EXT_BIT]) |=> ext_f);

endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_ovf = 0, ext_pin = 1, stat_we = 0, mask_we = 0;
  logic gie_set = 0, gie_clr = 0, ret_strobe = 0;
  logic [7:0] stat_wdata = 8'hFF, mask_wdata = 8'h00;
  logic [7:0] stat_rdata, mask_rdata;
  logic irq_req;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .ret_strobe(ret_strobe), .stat_rdata(stat_rdata),
    .mask_rdata(mask_rdata), .irq_req(irq_req));

  function automatic logic [39:0] v(
    input logic t, e, sw, input logic [7:0] sd, input logic mw,
    input logic [7:0] md, input logic gs, gc, rt,
    input logic [7:0] xs, xm, input logic xi);
    return {t, e, sw, sd, mw, md, gs, gc, rt, xs, xm, xi};
  endfunction

  localparam int NV = 19;
  localparam logic [39:0] VEC [NV] = '{
    v(0,1,0,8'hFF,0,8'h00,0,0,0, 8'h00,8'h00,0), // R1 idle
    v(1,1,0,8'hFF,0,8'h00,0,0,0, 8'h00,8'h00,0), // R2 masked set
    v(0,1,0,8'hFF,1,8'hFF,0,0,0, 8'h01,8'h09,0), // R6 R5
    v(0,1,0,8'hFF,0,8'h00,1,0,0, 8'h01,8'h09,1), // R8 R7
    v(0,1,0,8'hFF,0,8'h00,0,0,0, 8'h01,8'h09,0), // R9 take
    v(0,1,1,8'hFE,0,8'h00,0,0,0, 8'h00,8'h09,0), // R4 clear
    v(0,0,0,8'hFF,0,8'h00,0,0,0, 8'h08,8'h09,0), // R3 fall
    v(0,0,0,8'hFF,0,8'h00,0,0,1, 8'h08,8'h09,1), // R8 return
    v(0,0,0,8'hFF,0,8'h00,0,0,0, 8'h08,8'h09,0), // R9
    v(0,1,1,8'h00,0,8'h00,0,0,0, 8'h00,8'h09,0), // R4 R3 rise
    v(0,1,0,8'hFF,0,8'h00,0,0,0, 8'h00,8'h09,0), // R3 level
    v(0,1,1,8'hFF,0,8'h00,0,0,0, 8'h00,8'h09,0), // R4 no set
    v(1,1,0,8'hFF,0,8'h00,1,1,0, 8'h01,8'h09,0), // R8 clr wins
    v(1,1,1,8'h00,0,8'h00,0,0,0, 8'h01,8'h09,0), // R10
    v(0,1,0,8'hFF,1,8'h08,0,0,0, 8'h00,8'h08,0), // R6 R5
    v(0,1,0,8'hFF,0,8'h00,1,0,0, 8'h00,8'h08,0), // R7 nothing hit
    v(0,0,0,8'hFF,0,8'h00,0,0,0, 8'h08,8'h08,1), // R7 R3
    v(0,0,0,8'hFF,0,8'h00,0,0,0, 8'h08,8'h08,0), // R9
    v(0,0,0,8'hFF,1,8'h00,0,0,0, 8'h00,8'h00,0)  // R5
  };

  task automatic chk(input string req, input logic [7:0] act, exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic step(input logic t, e, sw, input logic [7:0] sd,
                      input logic mw, input logic [7:0] md,
                      input logic gs, gc, rt);
    tmr_ovf = t; ext_pin = e; stat_we = sw; stat_wdata = sd;
    mask_we = mw; mask_wdata = md; gie_set = gs; gie_clr = gc; ret_strobe = rt;
    @(posedge clk);
    @(negedge clk);
    tmr_ovf = 0; stat_we = 0; mask_we = 0; gie_set = 0; gie_clr = 0; ret_strobe = 0;
  endtask

  task automatic check3(input string req, input logic [7:0] xs, xm, input logic xi);
    chk({req, " stat"}, stat_rdata, xs);
    chk({req, " mask"}, mask_rdata, xm);
    chk({req, " irq"}, {7'd0, irq_req}, {7'd0, xi});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check3("R1 in reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic t, e, sw, mw, gs, gc, rt, xi;
      logic [7:0] sd, md, xs, xm;
      {t, e, sw, sd, mw, md, gs, gc, rt, xs, xm, xi} = VEC[i];
      step(t, e, sw, sd, mw, md, gs, gc, rt);
      check3($sformatf("vector %0d", i), xs, xm, xi);
    end

    // R1: reset mid-run clears flags, mask and enable
    ext_pin = 1'b1;
    step(0,1,0,8'hFF,1,8'hFF,1,0,0);
    rst_n = 1'b0;
    #1;
    check3("R1 mid-run reset", 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0,1,0,8'hFF,1,8'hFF,0,0,0);
    check3("R1 flags cleared by reset", 8'h00, 8'h09, 1'b0);

    // R10: external fall with same-cycle clear
    step(0,0,1,8'h00,0,8'h00,0,0,0);
    check3("R10 ext set wins", 8'h08, 8'h09, 1'b0);

    // R7: enable first, then unmask raises request
    step(0,0,0,8'hFF,1,8'h00,0,0,0);
    step(0,0,0,8'hFF,0,8'h00,1,0,0);
    check3("R7 enabled but masked", 8'h00, 8'h00, 1'b0);
    step(0,0,0,8'hFF,1,8'h08,0,0,0);
    check3("R7 unmask raises request", 8'h08, 8'h08, 1'b1);
    step(0,0,0,8'hFF,0,8'h00,0,0,1);
    check3("R9 take beats return", 8'h08, 8'h08, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule